// File: doc/BRIEF.md
# Comparator Offset Calibration Sequencer

This block runs the digital trim of a time-interleaved flash converter's comparator array: 8 slices, each with 15 comparators, each comparator carrying a 4-bit offset-correction code. After a start pulse it visits the comparators one at a time. For each one it names the comparator on its stimulus-select outputs, so that an external source can hold the input at that comparator's switching level. It then walks the trim code one step at a time until the comparator's decision flips, and keeps the code at the flip in that comparator's own register.

Every decision is a majority vote over 16 consecutive samples, which rejects noise of about half an LSB. After each code change a programmable settling time passes before voting starts. A comparator that reaches the end of the code range without flipping is marked as saturated and skipped. When the last comparator of the last slice is finished, a done level is raised. While the sequencer is idle, a host can write any trim register directly. All codes and flags are visible at all times on flat output buses.

Top module: `cmp_trim_seq`

## Requirements
- R1: After reset, done and stim_en are 0, every trim code is 8 (4'b1000) and every saturate flag is 0.
- R2: Comparators are visited in flat order 0 to 119, where flat index = slice*15 + comparator. During a visit, stim_slice and stim_cmp name it and stim_en is 1. Trim code i sits at trim_codes[4i+3:4i], saturate flag i at sat_flags[i], and comparator output i at cmp_in[i].
- R3: When a visit begins, that entry's code is loaded with 8 and its saturate flag is cleared. The first vote gives the polarity: 1 means the code is then decremented, 0 means it is incremented.
- R4: Each later step moves the code by exactly one in the fixed direction. The first vote that differs from the polarity ends the visit, and the code then in place is kept.
- R5: If a vote matches the polarity while the code is 0 (when decrementing) or 15 (when incrementing), the saturate flag is set, the code stays at that limit and the next comparator is visited.
- R6: A vote takes 16 samples of the selected cmp_in bit and yields 1 only if more than 8 of them are 1.
- R7: After every code load, settle_cycles+1 cycles pass before the first vote sample, so every vote round lasts settle_cycles+17 cycles.
- R8: done rises on the clock edge that ends the final round, stays 1 until the next start, and is cleared by the edge that accepts start. A start pulse during calibration is ignored.
- R9: While idle or done, host_we writes host_data into entry host_addr on the next edge. Writes during calibration are ignored, and so are addresses of 120 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a full calibration pass when idle or done |
| settle_cycles | input | 8 | Extra wait cycles after each code change |
| cmp_in | input | 120 | Sampled comparator decisions, flat index order |
| host_we | input | 1 | Direct trim write strobe |
| host_addr | input | 7 | Flat index of the entry to write |
| host_data | input | 4 | Code to write |
| done | output | 1 | Calibration pass complete |
| stim_en | output | 1 | Calibration in progress, stimulus select valid |
| stim_slice | output | 3 | Slice of the comparator under test |
| stim_cmp | output | 4 | Comparator within the slice under test |
| trim_codes | output | 480 | All trim codes, 4 bits per entry |
| sat_flags | output | 120 | Saturate flag per entry |

## Verification
A wrong step direction or a skipped step leaves a final code that differs from the threshold modelled in the bench. An early or late exit from a vote changes the round count, so done rises on a different cycle than the bench computes. A faulty settle or vote counter moves done by a whole number of cycles on the first affected round, and the bench measures this exactly. A corrupted visit index shows up on the next comparator change, as a jump in the stimulus select or as a fresh entry that does not hold code 8.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_VOTE   = 2'd2,
    ST_DONE   = 2'd3
  } cal_state_e;

endpackage

// File: rtl/cal_vote.sv
module cal_vote #(
  parameter int VOTE_N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic smp,
  output logic last,
  output logic maj
);
  localparam int CW  = $clog2(VOTE_N);
  localparam int OW  = $clog2(VOTE_N + 1);
  localparam int OW1 = OW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0] ones_q, ones_d;
  logic [OW:0]   total;

  always_comb begin
    cnt_d  = cnt_q;
    ones_d = ones_q;
    if (clr) begin
      cnt_d  = '0;
      ones_d = '0;
    end else if (en) begin
      cnt_d  = cnt_q + 1'b1;
      ones_d = ones_q + OW'(smp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ones_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
    end
  end

  assign total = {1'b0, ones_q} + OW1'(smp);
  assign last  = en && (cnt_q == CW'(VOTE_N - 1));
  assign maj   = total > OW1'(VOTE_N / 2);

  // R6: ones never outrun the samples taken
  a_r6_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ({1'b0, ones_q} <= OW1'(cnt_q)));

endmodule

// File: rtl/cal_trim_bank.sv
module cal_trim_bank #(
  parameter int NENT = 120,
  parameter int TW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 wr_en,
  input  logic                 wr_init,
  input  logic [$clog2(NENT)-1:0] wr_addr,
  input  logic [TW-1:0]        wr_data,
  input  logic                 sat_set,
  input  logic [$clog2(NENT)-1:0] sat_addr,
  input  logic                 host_we,
  input  logic [$clog2(NENT)-1:0] host_addr,
  input  logic [TW-1:0]        host_data,
  output logic [NENT*TW-1:0]   codes_o,
  output logic [NENT-1:0]      sat_o
);
  localparam int AW = $clog2(NENT);
  localparam logic [TW-1:0] MID = TW'(1 << (TW - 1));

  logic [TW-1:0] code_q [NENT];
  logic [NENT-1:0] sat_q;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic [TW-1:0] code_d;
    logic          sat_d;
    logic          cal_hit, host_hit, sat_hit;

    assign cal_hit  = wr_en && (wr_addr == AW'(i));
    assign host_hit = host_we && !busy && (host_addr == AW'(i));
    assign sat_hit  = sat_set && (sat_addr == AW'(i));

    always_comb begin
      code_d = code_q[i];
      if (cal_hit)       code_d = wr_data;
      else if (host_hit) code_d = host_data;
    end

    always_comb begin
      sat_d = sat_q[i];
      if (cal_hit && wr_init) sat_d = 1'b0;
      else if (sat_hit)       sat_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[i] <= MID;
        sat_q[i]  <= 1'b0;
      end else begin
        code_q[i] <= code_d;
        sat_q[i]  <= sat_d;
      end
    end

    assign codes_o[i*TW +: TW] = code_q[i];
  end

  assign sat_o = sat_q;

  // R3: a visit always opens at mid-scale
  a_r3_init_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_init) |-> (wr_data == MID));

  // R4: search writes move the stored code by one
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_init) |->
      ((wr_data == code_q[wr_addr] + 1'b1) || (wr_data == code_q[wr_addr] - 1'b1)));

  // R5: saturation only marked at an end of the code range
  a_r5_sat_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    sat_set |-> ((code_q[sat_addr] == '0) || (code_q[sat_addr] == '1)));

  // R9: host writes have no effect while calibrating
  a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en) |=> $stable(codes_o));

endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
  import cal_pkg::*;
#(
  parameter int NSL  = 8,
  parameter int NCMP = 15,
  parameter int TW   = 4,
  parameter int SETW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [SETW-1:0]             settle_cycles,
  input  logic                        vote_last,
  input  logic                        vote_maj,
  output logic                        busy,
  output logic                        done,
  output logic [$clog2(NSL)-1:0]      slice_o,
  output logic [$clog2(NCMP)-1:0]     cmp_o,
  output logic [$clog2(NSL*NCMP)-1:0] idx_o,
  output logic                        wr_en,
  output logic                        wr_init,
  output logic [$clog2(NSL*NCMP)-1:0] wr_addr,
  output logic [TW-1:0]               wr_data,
  output logic                        sat_set,
  output logic                        vote_clr,
  output logic                        vote_en
);
  localparam int NENT = NSL * NCMP;
  localparam int AW   = $clog2(NENT);
  localparam int SW   = $clog2(NSL);
  localparam int CW   = $clog2(NCMP);
  localparam logic [TW-1:0] MID      = TW'(1 << (TW - 1));
  localparam logic [TW-1:0] MAXC     = {TW{1'b1}};
  localparam logic [AW-1:0] LAST     = AW'(NENT - 1);
  localparam logic [CW-1:0] CMP_LAST = CW'(NCMP - 1);

  cal_state_e      state_q, state_d;
  logic [SETW-1:0] cnt_q, cnt_d;
  logic [SW-1:0]   slice_q, slice_d;
  logic [CW-1:0]   cmp_q, cmp_d;
  logic [AW-1:0]   idx_q, idx_d;
  logic [TW-1:0]   code_q, code_d;
  logic            pol_q, pol_d;
  logic            first_q, first_d;

  logic            dir_dn, at_lim, do_step, do_adv;
  logic [TW-1:0]   step_code;

  assign dir_dn    = first_q ? vote_maj : pol_q;
  assign at_lim    = pol_q ? (code_q == '0) : (code_q == MAXC);
  assign step_code = dir_dn ? (code_q - 1'b1) : (code_q + 1'b1);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    slice_d  = slice_q;
    cmp_d    = cmp_q;
    idx_d    = idx_q;
    code_d   = code_q;
    pol_d    = pol_q;
    first_d  = first_q;
    wr_en    = 1'b0;
    wr_init  = 1'b0;
    wr_addr  = idx_q;
    wr_data  = code_q;
    sat_set  = 1'b0;
    vote_clr = 1'b0;
    vote_en  = 1'b0;
    do_step  = 1'b0;
    do_adv   = 1'b0;

    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          slice_d = '0;
          cmp_d   = '0;
          idx_d   = '0;
          code_d  = MID;
          first_d = 1'b1;
          cnt_d   = settle_cycles;
          wr_en   = 1'b1;
          wr_init = 1'b1;
          wr_addr = '0;
          wr_data = MID;
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        vote_clr = 1'b1;
        if (cnt_q == '0) state_d = ST_VOTE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_VOTE: begin
        vote_en = 1'b1;
        if (vote_last) begin
          if (first_q) begin
            pol_d   = vote_maj;
            first_d = 1'b0;
            do_step = 1'b1;
          end else if (vote_maj != pol_q) begin
            do_adv = 1'b1;
          end else if (at_lim) begin
            sat_set = 1'b1;
            do_adv  = 1'b1;
          end else begin
            do_step = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (do_step) begin
      code_d  = step_code;
      wr_en   = 1'b1;
      wr_data = step_code;
      cnt_d   = settle_cycles;
      state_d = ST_SETTLE;
    end

    if (do_adv) begin
      if (idx_q == LAST) begin
        state_d = ST_DONE;
      end else begin
        idx_d = idx_q + 1'b1;
        if (cmp_q == CMP_LAST) begin
          cmp_d   = '0;
          slice_d = slice_q + 1'b1;
        end else begin
          cmp_d = cmp_q + 1'b1;
        end
        code_d  = MID;
        first_d = 1'b1;
        wr_en   = 1'b1;
        wr_init = 1'b1;
        wr_addr = idx_q + 1'b1;
        wr_data = MID;
        cnt_d   = settle_cycles;
        state_d = ST_SETTLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slice_q <= '0;
      cmp_q   <= '0;
      idx_q   <= '0;
      code_q  <= MID;
      pol_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slice_q <= slice_d;
      cmp_q   <= cmp_d;
      idx_q   <= idx_d;
      code_q  <= code_d;
      pol_q   <= pol_d;
      first_q <= first_d;
    end
  end

  assign busy    = (state_q == ST_SETTLE) || (state_q == ST_VOTE);
  assign done    = (state_q == ST_DONE);
  assign slice_o = slice_q;
  assign cmp_o   = cmp_q;
  assign idx_o   = idx_q;

  // checker counter: cycles since the last code load
  logic [SETW:0] since_wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_wr_q <= '0;
    else if (wr_en)              since_wr_q <= '0;
    else if (since_wr_q != '1)   since_wr_q <= since_wr_q + 1'b1;
  end

  // R7: voting starts exactly settle_cycles+1 cycles after a load
  a_r7_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VOTE && $past(state_q) == ST_SETTLE) |->
      (since_wr_q == ({1'b0, settle_cycles} + 1'b1)));

  // R2: visit index only advances by one or restarts at zero
  a_r2_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> ((idx_q == $past(idx_q) + 1'b1) || (idx_q == '0)));

  // R8: done only follows work on the final entry
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && $past(idx_q) == LAST));

endmodule

// File: rtl/cmp_trim_seq.sv
module cmp_trim_seq #(
  parameter int NSL    = 8,
  parameter int NCMP   = 15,
  parameter int TW     = 4,
  parameter int VOTE_N = 16,
  parameter int SETW   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [SETW-1:0]              settle_cycles,
  input  logic [NSL*NCMP-1:0]          cmp_in,
  input  logic                         host_we,
  input  logic [$clog2(NSL*NCMP)-1:0]  host_addr,
  input  logic [TW-1:0]                host_data,
  output logic                         done,
  output logic                         stim_en,
  output logic [$clog2(NSL)-1:0]       stim_slice,
  output logic [$clog2(NCMP)-1:0]      stim_cmp,
  output logic [NSL*NCMP*TW-1:0]       trim_codes,
  output logic [NSL*NCMP-1:0]          sat_flags
);
  localparam int NENT = NSL * NCMP;
  localparam int AW   = $clog2(NENT);

  logic          busy;
  logic [AW-1:0] idx;
  logic          wr_en, wr_init, sat_set;
  logic [AW-1:0] wr_addr;
  logic [TW-1:0] wr_data;
  logic          vote_clr, vote_en, vote_last, vote_maj;

  cal_fsm #(.NSL(NSL), .NCMP(NCMP), .TW(TW), .SETW(SETW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .settle_cycles (settle_cycles),
    .vote_last     (vote_last),
    .vote_maj      (vote_maj),
    .busy          (busy),
    .done          (done),
    .slice_o       (stim_slice),
    .cmp_o         (stim_cmp),
    .idx_o         (idx),
    .wr_en         (wr_en),
    .wr_init       (wr_init),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .sat_set       (sat_set),
    .vote_clr      (vote_clr),
    .vote_en       (vote_en)
  );

  cal_vote #(.VOTE_N(VOTE_N)) u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (vote_clr),
    .en    (vote_en),
    .smp   (cmp_in[idx]),
    .last  (vote_last),
    .maj   (vote_maj)
  );

  cal_trim_bank #(.NENT(NENT), .TW(TW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_init   (wr_init),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sat_set   (sat_set),
    .sat_addr  (idx),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_data (host_data),
    .codes_o   (trim_codes),
    .sat_o     (sat_flags)
  );

  assign stim_en = busy;

endmodule

// File: tb/cmp_trim_seq_test.sv
module cmp_trim_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NENT  = 120;
  localparam int LIMIT = 60000;
  // scenario: {noise[13], settle[12:5], seed[4:0]}
  localparam logic [13:0] SCN [3] = '{
    {1'b0, 8'd0,  5'd3},
    {1'b1, 8'd3,  5'd7},
    {1'b0, 8'd12, 5'd11}
  };

  logic         clk = 1'b0;
  logic         rst_n, start, host_we;
  logic [7:0]   settle_cycles;
  logic [NENT-1:0] cmp_in;
  logic [6:0]   host_addr;
  logic [3:0]   host_data;
  logic         done, stim_en;
  logic [2:0]   stim_slice;
  logic [3:0]   stim_cmp;
  logic [NENT*4-1:0] trim_codes;
  logic [NENT-1:0]   sat_flags;

  logic [4:0]   thr [NENT];
  logic         noise_on;
  logic [31:0]  cyc;
  int n_chk, n_fail;

  cmp_trim_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .cmp_in(cmp_in), .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .done(done), .stim_en(stim_en), .stim_slice(stim_slice), .stim_cmp(stim_cmp),
    .trim_codes(trim_codes), .sat_flags(sat_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  // comparator model: flips when code reaches its threshold; optional noise on 4 of every 16 samples
  always_comb begin
    for (int i = 0; i < NENT; i++)
      cmp_in[i] = ({1'b0, trim_codes[i*4 +: 4]} >= thr[i]) ^ (noise_on && cyc[1:0] == 2'b00);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int t);
    if (t == 0) return 0;
    if (t <= 8) return t - 1;
    if (t <= 15) return t;
    return 15;
  endfunction

  function automatic int exp_sat(input int t);
    return (t == 0 || t == 16) ? 1 : 0;
  endfunction

  function automatic int rounds(input int t);
    if (t == 0) return 9;
    if (t <= 8) return 10 - t;
    if (t <= 15) return t - 7;
    return 8;
  endfunction

  function automatic int code_at(input int i);
    return int'(trim_codes[i*4 +: 4]);
  endfunction

  task automatic run_cal(input int settle, input bit poke);
    int n, prev, visits, exp_t, sum_r, flat;
    bit order_ok, init_ok;
    int e0;
    settle_cycles = 8'(settle);
    sum_r = 0;
    for (int i = 0; i < NENT; i++) sum_r += rounds(int'(thr[i]));
    exp_t = sum_r * (settle + 17);
    e0 = exp_code(int'(thr[0]));
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R8 done cleared by start", int'(done), 0);
    n = 0; prev = -1; visits = 0; order_ok = 1'b1; init_ok = 1'b1;
    while (!done && n < LIMIT) begin
      if (stim_en) begin
        flat = int'(stim_slice) * 15 + int'(stim_cmp);
        if (flat != prev) begin
          if (flat != prev + 1) order_ok = 1'b0;
          if (code_at(flat) != 8 || sat_flags[flat]) init_ok = 1'b0;
          visits++;
          prev = flat;
        end
      end
      if (poke && n == 3000) begin
        start = 1'b1; host_we = 1'b1; host_addr = 7'd0; host_data = 4'(~e0);
      end
      if (poke && n == 3001) begin
        start = 1'b0; host_we = 1'b0;
      end
      @(negedge clk); n++;
    end
    check(n < LIMIT, "watchdog", n, exp_t);
    check(n == exp_t, "R7 round timing / R8 done edge", n, exp_t);
    check(order_ok && visits == NENT, "R2 visit order", visits, NENT);
    check(init_ok, "R3 visit starts at 8 with flag clear", int'(init_ok), 1);
    for (int i = 0; i < NENT; i++) begin
      check(code_at(i) == exp_code(int'(thr[i])), noise_on ? "R6 code under noise" : "R4 final code",
            code_at(i), exp_code(int'(thr[i])));
      check(int'(sat_flags[i]) == exp_sat(int'(thr[i])), "R5 saturate flag",
            int'(sat_flags[i]), exp_sat(int'(thr[i])));
    end
    if (poke) check(code_at(0) == e0, "R9 host write ignored while busy", code_at(0), e0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = '0;
    rst_n = 1'b0; start = 1'b0; host_we = 1'b0; host_addr = '0; host_data = '0;
    settle_cycles = '0; noise_on = 1'b0;
    for (int i = 0; i < NENT; i++) thr[i] = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(done == 1'b0 && stim_en == 1'b0, "R1 done/stim_en after reset", int'({done, stim_en}), 0);
    begin
      bit all_mid = 1'b1;
      for (int i = 0; i < NENT; i++) if (code_at(i) != 8) all_mid = 1'b0;
      check(all_mid, "R1 codes at 8", int'(all_mid), 1);
    end
    check(sat_flags == '0, "R1 flags clear", int'($countones(sat_flags)), 0);

    // R9 direct writes while idle, including an out-of-range address
    host_we = 1'b1; host_addr = 7'd5; host_data = 4'd3;
    @(negedge clk); host_addr = 7'd119; host_data = 4'd12;
    @(negedge clk); host_addr = 7'd127; host_data = 4'd1;
    @(negedge clk); host_we = 1'b0;
    check(code_at(5) == 3, "R9 idle write entry 5", code_at(5), 3);
    check(code_at(119) == 12, "R9 idle write entry 119", code_at(119), 12);
    begin
      bit rest_ok = 1'b1;
      for (int i = 0; i < NENT; i++) if (i != 5 && i != 119 && code_at(i) != 8) rest_ok = 1'b0;
      check(rest_ok, "R9 address 127 ignored", int'(rest_ok), 1);
    end

    // table-driven calibration passes
    for (int s = 0; s < 3; s++) begin
      noise_on = SCN[s][13];
      for (int i = 0; i < NENT; i++) thr[i] = 5'((i * int'(SCN[s][4:0]) + 5) % 17);
      run_cal(int'(SCN[s][12:5]), s == 1);
    end

    // R8 done holds until next start
    repeat (7) @(negedge clk);
    check(done == 1'b1, "R8 done holds", int'(done), 1);

    // R9 idle write after a pass
    host_we = 1'b1; host_addr = 7'd60; host_data = 4'd2;
    @(negedge clk); host_we = 1'b0;
    check(code_at(60) == 2, "R9 write after done", code_at(60), 2);
    check(done == 1'b1, "R8 host write leaves done", int'(done), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule